// File: doc/BRIEF.md
# Dual-Output Push-Pull PWM Controller

A clocked pulse-width modulator that steers alternate switching periods to two power-stage drive outputs. A counter serves as the ramp. Each period ends with a blanking interval during which both drives are held low. The end of that interval loads new settings and flips a steering bit. That bit decides which of the two drives may pulse in the next period. Each drive therefore switches at half the ramp rate. Neither drive can pulse beyond the active part of the period. If the two drives are OR-ed together, the result covers nearly the full period at the full ramp rate.

The duty command is compared with the ramp. A drive stays on from the start of its period until the ramp reaches the command. There are two protection inputs. Shutdown turns both drives off for as long as it is held. The current-limit flag turns them off at once and, in the default variant, keeps them off until the period ends. The blanking interval is visible on a sync output. A sync input can force the ramp into blanking early, so several instances can follow one master.

Top module: `pwm_pushpull_ctrl`

## Requirements
- R1: While reset is held, both drives are low and sync_o is high. The first period after reset release is steered to drive A.
- R2: The ramp counts 0 to P-1 and then wraps, where P = max(period_i, 2). sync_o is high during the last B cycles of every period.
- R3: The blanking length is B = min(max(blank_i, 1), P-1).
- R4: period_i and blank_i take effect only at the wrap that ends a blanking interval. A change in mid-period leaves the current period's length and blanking unchanged.
- R5: In a steered period, the selected drive is high while the ramp is below both the duty command and P-B. Its on-time is min(duty, P-B) cycles, and a command of 0 gives no pulse.
- R6: duty_i is sampled only at the wrap. A change in mid-period does not alter the pulse already in progress.
- R7: Periods go to drive A and drive B in strict alternation. The two drives are never high together, and both are low while sync_o is high.
- R8: shutdown_i forces both drives low in the same cycle. It leaves nothing behind: when it is released, the pulse resumes if the period still allows it.
- R9: ilim_i forces both drives low in the same cycle. In the latched variant (default) the drives stay low for the rest of that period. The latch is cleared at the wrap, and the clear takes priority over a flag raised in the wrap cycle itself.
- R10: If sync_i is high outside blanking, the ramp jumps to the first blanking cycle on the next clock, so blanking still lasts B cycles. If sync_i is high during blanking, it is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period_i | input | CNT_W | Requested period length in clocks |
| blank_i | input | CNT_W | Requested blanking length in clocks |
| duty_i | input | CNT_W | Duty command, compared with the ramp |
| shutdown_i | input | 1 | Forces both drives low while high |
| ilim_i | input | 1 | Current-limit flag |
| sync_i | input | 1 | External restart into blanking |
| sync_o | output | 1 | High during blanking |
| out_a_o | output | 1 | Drive A |
| out_b_o | output | 1 | Drive B |

## Verification
Two functions can fall in the same cycle. An external restart can arrive in the very cycle where the ramp enters blanking on its own, and a current-limit flag can coincide with the wrap that clears its latch. The bench raises sync_i on the last active ramp value and checks that blanking still lasts exactly B cycles. It also raises ilim_i on the final blanking cycle and checks that the next period delivers its full on-time. A restart held high through blanking must not stretch that blanking.

// File: rtl/pwm_pp_pkg.sv
package pwm_pp_pkg;
   typedef enum logic {
      SEL_A = 1'b0,
      SEL_B = 1'b1
   } steer_e;
endpackage

// File: rtl/pwm_pp_ramp.sv
module pwm_pp_ramp #(
   parameter int CNT_W      = 8,
   parameter int DEF_PERIOD = 16,
   parameter int DEF_BLANK  = 2,
   parameter int MIN_PERIOD = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] period_i,
   input  logic [CNT_W-1:0] blank_i,
   input  logic             sync_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] act_o,
   output logic             blank_o,
   output logic             wrap_o
);
   localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
   localparam logic [CNT_W-1:0] MIN_P   = CNT_W'(MIN_PERIOD);
   localparam logic [CNT_W-1:0] RST_PER = CNT_W'(DEF_PERIOD);
   localparam logic [CNT_W-1:0] RST_BLK = CNT_W'(DEF_BLANK);
   localparam logic [CNT_W-1:0] RST_CNT = RST_PER - ONE;

   if (CNT_W < 2) begin : g_bad_width
      $error("CNT_W must be at least 2");
   end
   if (MIN_PERIOD < 2 || MIN_PERIOD >= (1 << CNT_W)) begin : g_bad_min
      $error("MIN_PERIOD out of range");
   end
   if (DEF_PERIOD < MIN_PERIOD || DEF_PERIOD >= (1 << CNT_W)) begin : g_bad_per
      $error("DEF_PERIOD out of range");
   end
   if (DEF_BLANK < 1 || DEF_BLANK >= DEF_PERIOD) begin : g_bad_blk
      $error("DEF_BLANK out of range");
   end

   logic [CNT_W-1:0] cnt_q, per_q, blk_q;
   logic [CNT_W-1:0] per_new, blk_lo, blk_new;
   logic [CNT_W-1:0] act;
   logic             blank, wrap;

   // clamp requested settings
   always_comb begin
      per_new = (period_i < MIN_P) ? MIN_P : period_i;
      blk_lo  = (blank_i == '0) ? ONE : blank_i;
      blk_new = (blk_lo >= per_new) ? (per_new - ONE) : blk_lo;
   end

   assign act   = per_q - blk_q;
   assign blank = (cnt_q >= act);
   assign wrap  = (cnt_q == per_q - ONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= RST_CNT;
         per_q <= RST_PER;
         blk_q <= RST_BLK;
      end else if (wrap) begin
         cnt_q <= '0;
         per_q <= per_new;
         blk_q <= blk_new;
      end else if (sync_i && !blank) begin
         cnt_q <= act;
      end else begin
         cnt_q <= cnt_q + ONE;
      end
   end

   assign cnt_o   = cnt_q;
   assign act_o   = act;
   assign blank_o = blank;
   assign wrap_o  = wrap;

   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < per_q);                                               // R2
   AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (cnt_q == '0));                                      // R2
   AST_BLK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_q != '0) && (blk_q < per_q));                            // R3
   AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap |=> ($stable(per_q) && $stable(blk_q)));                // R4
   AST_SYNC_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_i && !blank) |=> blank);                                // R10
endmodule

// File: rtl/pwm_pp_steer.sv
module pwm_pp_steer
   import pwm_pp_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   wrap_i,
   output steer_e sel_o
);
   steer_e sel_q;

   // parked on B so the wrap leaving reset hands period one to A
   always_ff @(posedge clk) begin
      if (!rst_n)      sel_q <= SEL_B;
      else if (wrap_i) sel_q <= (sel_q == SEL_A) ? SEL_B : SEL_A;
   end

   assign sel_o = sel_q;

   AST_STEER_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_i |=> (sel_q != $past(sel_q)));                          // R7
   AST_STEER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap_i |=> $stable(sel_q));                                  // R7
endmodule

// File: rtl/pwm_pp_gate.sv
module pwm_pp_gate
   import pwm_pp_pkg::*;
#(
   parameter int CNT_W      = 8,
   parameter bit ILIM_LATCH = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [CNT_W-1:0] act_i,
   input  logic             wrap_i,
   input  steer_e           sel_i,
   input  logic [CNT_W-1:0] duty_i,
   input  logic             shutdown_i,
   input  logic             ilim_i,
   output logic [1:0]       drive_o
);
   logic [CNT_W-1:0] duty_q;
   logic             ilim_hold;
   logic             kill, pulse;

   always_ff @(posedge clk) begin
      if (!rst_n)      duty_q <= '0;
      else if (wrap_i) duty_q <= duty_i;
   end

   if (ILIM_LATCH) begin : g_ilim_latch
      logic hold_q;
      always_ff @(posedge clk) begin
         if (!rst_n)      hold_q <= 1'b0;
         else if (wrap_i) hold_q <= 1'b0;
         else if (ilim_i) hold_q <= 1'b1;
      end
      assign ilim_hold = hold_q;

      AST_ILIM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         (ilim_i && !wrap_i) |=> (drive_o == 2'b00));               // R9
   end else begin : g_ilim_pass
      assign ilim_hold = 1'b0;
   end

   assign kill  = shutdown_i | ilim_i | ilim_hold;
   assign pulse = (cnt_i < duty_q) && (cnt_i < act_i);

   for (genvar i = 0; i < 2; i++) begin : g_side
      localparam steer_e SIDE = (i == 0) ? SEL_A : SEL_B;
      assign drive_o[i] = pulse && !kill && (sel_i == SIDE);
   end

   AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(drive_o));                                           // R7
   AST_DUTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap_i |=> $stable(duty_q));                                 // R6
   AST_ZERO_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
      (duty_q == '0) |-> (drive_o == 2'b00));                       // R5
   AST_SHDN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      shutdown_i |-> (drive_o == 2'b00));                           // R8
   AST_ILIM_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      ilim_i |-> (drive_o == 2'b00));                               // R9
endmodule

// File: rtl/pwm_pushpull_ctrl.sv
module pwm_pushpull_ctrl
   import pwm_pp_pkg::*;
#(
   parameter int CNT_W      = 8,
   parameter int DEF_PERIOD = 16,
   parameter int DEF_BLANK  = 2,
   parameter int MIN_PERIOD = 2,
   parameter bit ILIM_LATCH = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] period_i,
   input  logic [CNT_W-1:0] blank_i,
   input  logic [CNT_W-1:0] duty_i,
   input  logic             shutdown_i,
   input  logic             ilim_i,
   input  logic             sync_i,
   output logic             sync_o,
   output logic             out_a_o,
   output logic             out_b_o
);
   logic [CNT_W-1:0] cnt, act;
   logic             blank, wrap;
   steer_e           sel;
   logic [1:0]       drive;

   pwm_pp_ramp #(
      .CNT_W(CNT_W), .DEF_PERIOD(DEF_PERIOD),
      .DEF_BLANK(DEF_BLANK), .MIN_PERIOD(MIN_PERIOD)
   ) u_ramp (
      .clk(clk), .rst_n(rst_n), .period_i(period_i), .blank_i(blank_i),
      .sync_i(sync_i), .cnt_o(cnt), .act_o(act), .blank_o(blank), .wrap_o(wrap)
   );

   pwm_pp_steer u_steer (
      .clk(clk), .rst_n(rst_n), .wrap_i(wrap), .sel_o(sel)
   );

   pwm_pp_gate #(.CNT_W(CNT_W), .ILIM_LATCH(ILIM_LATCH)) u_gate (
      .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .act_i(act), .wrap_i(wrap),
      .sel_i(sel), .duty_i(duty_i), .shutdown_i(shutdown_i), .ilim_i(ilim_i),
      .drive_o(drive)
   );

   assign sync_o  = blank;
   assign out_a_o = drive[0];
   assign out_b_o = drive[1];

   AST_BLANK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      sync_o |-> (!out_a_o && !out_b_o));                           // R7
endmodule

// File: tb/tb_pwm_pushpull_ctrl.sv
module tb_pwm_pushpull_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int CNT_W      = 8;
   localparam int NVEC       = 10;
   // period, blank, duty, expected P, expected B, expected on-time
   localparam int VEC [NVEC][6] = '{
      '{10, 2,   4, 10, 2,  4},
      '{10, 2,   0, 10, 2,  0},
      '{10, 2,   8, 10, 2,  8},
      '{10, 2, 200, 10, 2,  8},
      '{12, 0,  20, 12, 1, 11},
      '{ 8, 9,   5,  8, 7,  1},
      '{ 1, 1,   1,  2, 1,  1},
      '{20, 5,  15, 20, 5, 15},
      '{20, 5,  14, 20, 5, 14},
      '{ 0, 0,   3,  2, 1,  1}
   };

   logic clk = 1'b0;
   logic rst_n;
   logic [CNT_W-1:0] period_i, blank_i, duty_i;
   logic shutdown_i, ilim_i, sync_i;
   logic sync_o, out_a_o, out_b_o;

   int n_checks = 0;
   int n_errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pwm_pushpull_ctrl #(.CNT_W(CNT_W)) dut (
      .clk(clk), .rst_n(rst_n), .period_i(period_i), .blank_i(blank_i),
      .duty_i(duty_i), .shutdown_i(shutdown_i), .ilim_i(ilim_i),
      .sync_i(sync_i), .sync_o(sync_o), .out_a_o(out_a_o), .out_b_o(out_b_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #2;
   endtask

   // advance until the first cycle of a new period (sync_o falls)
   task automatic to_fall();
      bit prev;
      prev = sync_o;
      while (1) begin
         step();
         if (prev && !sync_o) break;
         prev = sync_o;
      end
   endtask

   // from a first-cycle state, count one whole period; ends on next first cycle
   task automatic measure(output int na, output int nb, output int ns, output int len, output int both);
      bit prev;
      #1;
      na = int'(out_a_o); nb = int'(out_b_o); ns = int'(sync_o); len = 1;
      both = int'(out_a_o && out_b_o);
      prev = sync_o;
      while (1) begin
         step();
         if (prev && !sync_o) break;
         na += int'(out_a_o); nb += int'(out_b_o); ns += int'(sync_o);
         both += int'(out_a_o && out_b_o) + int'(sync_o && (out_a_o || out_b_o));
         len++;
         prev = sync_o;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      int a1, b1, s1, l1, x1, a2, b2, s2, l2, x2, nh;
      rst_n = 1'b0; period_i = 10; blank_i = 2; duty_i = 3;
      shutdown_i = 1'b0; ilim_i = 1'b0; sync_i = 1'b0;
      repeat (3) step();
      #1;
      // R1 reset state
      check(!out_a_o && !out_b_o, "R1 drives low in reset", int'(out_a_o | out_b_o), 0);
      check(sync_o == 1'b1, "R1 sync high in reset", int'(sync_o), 1);
      rst_n = 1'b1;
      step();
      measure(a1, b1, s1, l1, x1);
      check(a1 == 3 && b1 == 0, "R1 first period on A", a1 * 100 + b1, 300);
      measure(a2, b2, s2, l2, x2);
      check(a2 == 0 && b2 == 3, "R7 second period on B", a2 * 100 + b2, 3);

      // table walk: R2 R3 R5 R7
      for (int v = 0; v < NVEC; v++) begin
         period_i = CNT_W'(VEC[v][0]);
         blank_i  = CNT_W'(VEC[v][1]);
         duty_i   = CNT_W'(VEC[v][2]);
         to_fall();
         measure(a1, b1, s1, l1, x1);
         measure(a2, b2, s2, l2, x2);
         check(l1 == VEC[v][3] && l2 == VEC[v][3], "R2 period length", l1, VEC[v][3]);
         check(s1 == VEC[v][4] && s2 == VEC[v][4], "R3 blanking length", s1, VEC[v][4]);
         check(a1 + a2 == VEC[v][5], "R5 on-time drive A", a1 + a2, VEC[v][5]);
         check(b1 + b2 == VEC[v][5], "R5 on-time drive B", b1 + b2, VEC[v][5]);
         check(x1 == 0 && x2 == 0 && (a1 == 0 || b1 == 0) && (a2 == 0 || b2 == 0),
               "R7 exclusive and quiet in blanking", x1 + x2, 0);
      end

      // R4 R6: settings changed in the first cycle of a period
      period_i = 20; blank_i = 5; duty_i = 6;
      to_fall();
      measure(a1, b1, s1, l1, x1);
      period_i = 12; duty_i = 10;
      measure(a1, b1, s1, l1, x1);
      check(l1 == 20, "R4 length held until wrap", l1, 20);
      check(a1 + b1 == 6, "R6 duty held until wrap", a1 + b1, 6);
      measure(a2, b2, s2, l2, x2);
      check(l2 == 12, "R4 new length after wrap", l2, 12);
      check(a2 + b2 == 7, "R5 on-time capped at P-B", a2 + b2, 7);

      // R8 shutdown
      period_i = 20;
      measure(a1, b1, s1, l1, x1);
      step(); step();
      check(out_a_o || out_b_o, "R8 pulse present before shutdown", 0, 1);
      shutdown_i = 1'b1; #1;
      check(!out_a_o && !out_b_o, "R8 shutdown same cycle", int'(out_a_o | out_b_o), 0);
      step();
      check(!out_a_o && !out_b_o, "R8 shutdown held", int'(out_a_o | out_b_o), 0);
      shutdown_i = 1'b0; #1;
      check(out_a_o || out_b_o, "R8 pulse resumes after release", 0, 1);

      // R9 current limit latched for the rest of the period
      to_fall();
      step(); step();
      ilim_i = 1'b1; #1;
      check(!out_a_o && !out_b_o, "R9 limit same cycle", int'(out_a_o | out_b_o), 0);
      step();
      ilim_i = 1'b0; #1;
      check(!out_a_o && !out_b_o, "R9 limit latched", int'(out_a_o | out_b_o), 0);
      to_fall();
      measure(a1, b1, s1, l1, x1);
      check(a1 + b1 == 10, "R9 latch cleared next period", a1 + b1, 10);

      // R9 flag in the wrap cycle: clear wins
      repeat (19) step();
      check(sync_o == 1'b1, "R2 last cycle in blanking", int'(sync_o), 1);
      ilim_i = 1'b1;
      step();
      ilim_i = 1'b0;
      measure(a1, b1, s1, l1, x1);
      check(a1 + b1 == 10, "R9 flag on wrap not carried", a1 + b1, 10);

      // R10 sync input in active phase
      step(); step(); step();
      sync_i = 1'b1;
      step();
      sync_i = 1'b0; #1;
      check(sync_o && !out_a_o && !out_b_o, "R10 restart enters blanking", int'(sync_o), 1);
      nh = 0;
      while (sync_o) begin nh++; step(); end
      check(nh == 5, "R10 blanking length after restart", nh, 5);

      // R10 sync held during blanking is ignored
      repeat (15) step();
      sync_i = 1'b1;
      nh = 0;
      while (sync_o) begin
         nh++;
         step();
         if (nh == 3) sync_i = 1'b0;
      end
      sync_i = 1'b0;
      check(nh == 5, "R10 ignored during blanking", nh, 5);

      // R10 restart coinciding with natural blanking entry
      repeat (14) step();
      sync_i = 1'b1;
      step();
      sync_i = 1'b0; #1;
      nh = 0;
      while (sync_o) begin nh++; step(); end
      check(nh == 5, "R10 coincident restart", nh, 5);
      measure(a1, b1, s1, l1, x1);
      check(l1 == 20 && a1 + b1 == 10, "R2 period after coincident restart", l1, 20);

      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end
endmodule